// File: doc/BRIEF.md
# Quad 12-bit Converter Double-Buffered Register Interface

This block is the digital front end of a four-channel, 12-bit converter that sits on a parallel bus. A two-bit channel select, an active-low chip select and a read/write strobe steer a 12-bit data word into one of four staging registers. A second bank of four output registers supplies the codes that drive the converters. One shared active-low load strobe copies all staging registers into the output bank at the same time. This lets software stage new values one channel at a time and then change every output together. A staged value can also be read back over the bus.

Both banks behave like level-sensitive latches, modelled on a clock. While its enabling condition holds, a register follows its input on every clock. When the condition ends, it keeps its last value. An active-low clear forces every register to a reset code chosen at build time, either midscale (0x800) or zero. Registers that are latched when the clear is released keep that code. Codes are straight binary: code N stands for N/4096 of the reference span above the low reference.

Top module: `quad_dac_latch`

## Requirements
- R1: While `clear_n` is sampled low, all four staging registers and all four output codes are loaded with the reset code on that clock edge. The reset code is 0x800 when `RESET_MID` is 1 and 0x000 when it is 0.
- R2: A write is `cs_n`=0 with `rd_wr`=0. On a sampled write, the staging register picked by `sel` takes `din` (00=A, 01=B, 10=C, 11=D), and the other three are unchanged.
- R3: While `cs_n` is 1, no staging register changes, whatever `rd_wr`, `sel` and `din` are.
- R4: While `load_n` is 1, the four output codes hold their values.
- R5: While `load_n` is sampled 0, every output code takes its staging register's updated value on that edge. A write in the same cycle therefore reaches its output in one clock.
- R6: A readback is `cs_n`=0 with `rd_wr`=1. During a readback, `dout_en` is 1 and `dout` shows the staging register picked by `sel`. Readback changes no register.
- R7: After `clear_n` rises, every register keeps the reset code until it is written or loaded.
- R8: A sampled low `clear_n` overrides any write or load in the same cycle.
- R9: When no readback is in progress, `dout_en` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which the latch behaviour is sampled |
| clear_n | input | 1 | Active-low clear that loads the reset code |
| sel | input | 2 | Channel select (00=A, 01=B, 10=C, 11=D) |
| cs_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = readback, 0 = write |
| load_n | input | 1 | Active-low shared load into the output bank |
| din | input | 12 | Data written to a staging register |
| dout | output | 12 | Readback data |
| dout_en | output | 1 | Drive enable for the readback data |
| code_a | output | 12 | Output code, channel A |
| code_b | output | 12 | Output code, channel B |
| code_c | output | 12 | Output code, channel C |
| code_d | output | 12 | Output code, channel D |

## Verification
The assertions assume that the controls are steady and valid around each clock edge. They also assume that `clear_n` is held low from time zero, so the first sampled state is the reset state. The bench changes every input one time unit after a rising edge, starts with the clear asserted, and runs with both reset codes at once. The same stimulus goes to two instances, one built with each value of `RESET_MID`.

// File: rtl/quad_dac_latch.sv
module quad_dac_latch #(
  parameter int CODE_W    = 12,
  parameter bit RESET_MID = 1'b1
) (
  input  logic              clk,
  input  logic              clear_n,
  input  logic [1:0]        sel,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic              load_n,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] dout,
  output logic              dout_en,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] code_c,
  output logic [CODE_W-1:0] code_d
);
  localparam int NCH = 4;
  localparam logic [CODE_W-1:0] RST_CODE =
    RESET_MID ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  logic [CODE_W-1:0] stage_q [NCH];
  logic [CODE_W-1:0] stage_d [NCH];
  logic [CODE_W-1:0] out_q   [NCH];

  wire wr_en = !cs_n && !rd_wr;
  wire rd_en = !cs_n &&  rd_wr;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_comb
      stage_d[ch] = (wr_en && sel == 2'(ch)) ? din : stage_q[ch];

    always_ff @(posedge clk) begin
      if (!clear_n) begin
        stage_q[ch] <= RST_CODE;
        out_q[ch]   <= RST_CODE;
      end else begin
        stage_q[ch] <= stage_d[ch];
        if (!load_n) out_q[ch] <= stage_d[ch];
      end
    end
  end

  assign dout_en = rd_en;
  assign dout    = rd_en ? stage_q[sel] : '0;
  assign code_a  = out_q[0];
  assign code_b  = out_q[1];
  assign code_c  = out_q[2];
  assign code_d  = out_q[3];
endmodule

// File: rtl/quad_dac_latch_chk.sv
module quad_dac_latch_chk #(
  parameter int CODE_W    = 12,
  parameter bit RESET_MID = 1'b1
) (
  input logic              clk,
  input logic              clear_n,
  input logic [1:0]        sel,
  input logic              cs_n,
  input logic              rd_wr,
  input logic              load_n,
  input logic [CODE_W-1:0] din,
  input logic [CODE_W-1:0] dout,
  input logic              dout_en,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic [CODE_W-1:0] code_c,
  input logic [CODE_W-1:0] code_d
);
  localparam logic [CODE_W-1:0] RC =
    RESET_MID ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  assert_clear_codes_R1: assert property (@(posedge clk)
    !clear_n |=> (code_a == RC && code_b == RC && code_c == RC && code_d == RC));

  assert_hold_codes_R4: assert property (@(posedge clk) disable iff (!clear_n)
    load_n |=> $stable({code_a, code_b, code_c, code_d}));

  assert_load_from_stage_R5: assert property (@(posedge clk) disable iff (!clear_n)
    (!load_n && dout_en && sel == 2'd0) |=> code_a == $past(dout));

  assert_no_drive_deselected_R6: assert property (@(posedge clk) disable iff (!clear_n)
    cs_n |-> !dout_en);

  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!clear_n)
    !dout_en |-> dout == '0);
endmodule

bind quad_dac_latch quad_dac_latch_chk #(.CODE_W(CODE_W), .RESET_MID(RESET_MID)) u_chk (.*);

// File: tb/sim_quad_dac_latch.sv
module sim_quad_dac_latch;
  logic clk = 1'b0;
  logic clear_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic cs_n = 1'b1, rd_wr = 1'b1, load_n = 1'b1;
  logic [11:0] din = 12'h000;
  logic [11:0] dout0, dout1, ca0, cb0, cc0, cd0, ca1, cb1, cc1, cd1;
  logic en0, en1;
  int errors = 0, checks = 0, cyc = 0;
  int m_in [2][4];
  int m_out[2][4];
  int rc[2] = '{32'h800, 32'h000};

  always #4 clk = ~clk;

  quad_dac_latch #(.CODE_W(12), .RESET_MID(1'b1)) u0 (
    .clk, .clear_n, .sel, .cs_n, .rd_wr, .load_n, .din,
    .dout(dout0), .dout_en(en0), .code_a(ca0), .code_b(cb0), .code_c(cc0), .code_d(cd0));
  quad_dac_latch #(.CODE_W(12), .RESET_MID(1'b0)) u1 (
    .clk, .clear_n, .sel, .cs_n, .rd_wr, .load_n, .din,
    .dout(dout1), .dout_en(en1), .code_a(ca1), .code_b(cb1), .code_c(cc1), .code_d(cd1));

  always @(posedge clk) begin
    cyc++;
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 4; c++) begin
        if (!clear_n) begin
          m_in[k][c] = rc[k];
          m_out[k][c] = rc[k];
        end else begin
          if (!cs_n && !rd_wr && int'(sel) == c) m_in[k][c] = int'(din);
          if (!load_n) m_out[k][c] = m_in[k][c];
        end
      end
    end
  end

  function automatic logic [60:0] expect_of(int k);
    logic rd;
    logic [11:0] rv;
    rd = !cs_n && rd_wr;
    rv = rd ? 12'(m_in[k][int'(sel)]) : 12'h000;
    return {12'(m_out[k][3]), 12'(m_out[k][2]), 12'(m_out[k][1]), 12'(m_out[k][0]), rd, rv};
  endfunction

  task automatic compare(string tag);
    logic [60:0] act[2], exp[2];
    act[0] = {cd0, cc0, cb0, ca0, en0, dout0};
    act[1] = {cd1, cc1, cb1, ca1, en1, dout1};
    for (int k = 0; k < 2; k++) begin
      exp[k] = expect_of(k);
      checks++;
      if (act[k] !== exp[k]) begin
        errors++;
        $display("FAIL %s inst%0d: actual=%h expected=%h", tag, k, act[k], exp[k]);
      end
    end
  endtask

  task automatic step(logic clr, logic cs, logic rw, logic ld, logic [1:0] a,
                      logic [11:0] d, string tag);
    clear_n = clr; cs_n = cs; rd_wr = rw; load_n = ld; sel = a; din = d;
    #0;
    compare(tag);
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    @(posedge clk); #1;
    step(0, 1, 1, 1, 0, 12'h123, "R1");
    step(0, 0, 0, 0, 1, 12'h456, "R1");
    step(1, 1, 1, 1, 0, 12'h000, "R7");
    step(1, 1, 0, 1, 2, 12'h777, "R7");
    for (int c = 0; c < 4; c++) step(1, 0, 1, 1, 2'(c), 12'hFFF, "R7");
    step(0, 1, 1, 0, 0, 12'h000, "R1");
    step(1, 1, 1, 0, 0, 12'h000, "R7");
    step(1, 1, 1, 1, 0, 12'h000, "R7");
    step(1, 0, 0, 1, 0, 12'hA01, "R2");
    step(1, 0, 0, 1, 1, 12'hB02, "R2");
    step(1, 0, 0, 1, 2, 12'hC03, "R2");
    step(1, 0, 0, 1, 3, 12'hD04, "R4");
    step(1, 1, 0, 1, 1, 12'h5A5, "R3");
    step(1, 1, 1, 1, 2, 12'h3C3, "R3");
    for (int c = 0; c < 4; c++) step(1, 0, 1, 1, 2'(c), 12'h000, "R6");
    step(1, 1, 1, 0, 0, 12'h000, "R5");
    step(1, 1, 1, 1, 0, 12'h000, "R9");
    step(1, 0, 0, 1, 2, 12'h0FF, "R2");
    step(1, 0, 1, 1, 2, 12'h000, "R6");
    step(1, 1, 1, 0, 0, 12'h000, "R5");
    step(1, 0, 0, 0, 3, 12'hE0E, "R5");
    step(1, 0, 0, 0, 0, 12'h00F, "R5");
    step(1, 0, 1, 0, 0, 12'h000, "R6");
    step(0, 0, 0, 0, 1, 12'hFFE, "R8");
    step(1, 0, 1, 1, 1, 12'h000, "R8");
    for (int i = 0; i < 400; i++)
      step(($urandom % 23) != 0, $urandom % 2 == 0, $urandom % 3 == 0,
           $urandom % 4 == 0, 2'($urandom), 12'($urandom), "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    errors++;
    $display("FAIL watchdog: actual=%0d cycles expected<50000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule